// File: doc/BRIEF.md
# Boot Image Selection Sequencer

This block is the control state machine that, once reset is released, decides which boot image the processor runs. It reads a set of configuration inputs: the boot-source code, the on-chip warm-image enable and length, the index of the flash slot that last loaded successfully, the software-state word and a flag that says whether the reset came from the watchdog. From these it walks a fixed priority order. The warm image in on-chip RAM comes first. Next come the four flash image slots, starting from a computed slot and rotating. Last comes a fallback image in the FPGA fabric.

The sequencer moves no data and computes no checksum. For each candidate it sends a single-cycle request carrying an image kind and a start address to an external validator, then waits for a one-cycle pass or fail answer. There is no back-pressure on this link. The validator must take every request pulse when it is issued and answer each one exactly once. The sequencer never has more than one request outstanding. When the sequence ends, the block holds three things until the next reset: the chosen execution address, the image index to record for the next boot, and exactly one of three status flags (done, fallback or fatal). All configuration inputs must stay stable from reset release until a status flag is raised.

Top module: `boot_image_seq`

## Requirements
- R1: While reset is asserted, `boot_done`, `boot_fallback`, `boot_fatal` and `val_req` are 0, and `exec_addr` and `img_idx` are 0.
- R2: Boot code 0 is reserved. It raises `boot_fatal` and issues no validator request, even when the warm image is enabled.
- R3: With a non-reserved code, `warm_en`=1 and `warm_len`=0, the block raises `boot_done` with `exec_addr`=0xFFFF0000 and issues no request.
- R4: With a non-reserved code, `warm_en`=1 and a nonzero `warm_len`, the block first issues one request with kind 0 (warm on-chip image) at address 0xFFFF0000. A pass ends with `boot_done` at that address. A fail continues with the cold path that the boot code selects.
- R5: With boot code 1 (FPGA direct) on the cold path, the block issues no request and waits until `fpga_ready` is 1. It then raises `boot_done` with `exec_addr`=0xC0000000.
- R6: With boot codes 2 to 7 on the cold path, the first flash slot tried is `last_idx`. It is `last_idx`+1 modulo 4 instead when `wdog_rst`=1 and `sw_state` differs from the magic word 0x49535756.
- R7: Flash slots are requested with kind 1 at address slot×0x10000. Up to four slots are tried, rising by one modulo 4 from the first. The first pass raises `boot_done` with `exec_addr` equal to that slot's address and `img_idx` equal to that slot.
- R8: If all four slots fail, one request with kind 2 (FPGA fallback) is issued at 0xC0000000. A pass raises `boot_fallback` with `exec_addr`=0xC0000000. `img_idx` always equals the first slot tried unless a slot passed.
- R9: If the fallback check fails, the block raises `boot_fatal` (post-mortem wait), keeps `exec_addr` at 0 and issues no further request until reset.
- R10: `val_req` is never high in two consecutive cycles. A `val_pass` or `val_fail` pulse that arrives while no request is outstanding has no effect.
- R11: At most one status flag is high. Once a flag is raised, the flags, `exec_addr` and `img_idx` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; sequencing starts on release |
| boot_code | input | 3 | Boot source: 0 reserved, 1 FPGA direct, 2..7 flash |
| warm_en | input | 1 | Warm on-chip image enabled |
| warm_len | input | LEN_W (16) | Warm image length; 0 means run without a check |
| last_idx | input | SLOT_W (2) | Slot that loaded last time |
| sw_state | input | 32 | Software-state word; magic 0x49535756 means the preloader reached a valid state |
| wdog_rst | input | 1 | The reset came from the watchdog |
| fpga_ready | input | 1 | FPGA fabric is in user mode |
| val_pass | input | 1 | Validator: image accepted (one-cycle pulse) |
| val_fail | input | 1 | Validator: image rejected (one-cycle pulse) |
| val_req | output | 1 | Validation request pulse |
| val_kind | output | 2 | Request kind: 0 warm, 1 flash slot, 2 FPGA fallback, 3 idle |
| val_addr | output | ADDR_W (32) | Start address of the image to validate |
| exec_addr | output | ADDR_W (32) | Chosen execution address |
| img_idx | output | SLOT_W (2) | Image index to record for the next boot |
| boot_done | output | 1 | Primary image chosen |
| boot_fallback | output | 1 | FPGA fallback image chosen |
| boot_fatal | output | 1 | Post-mortem wait |

## Verification
The selection logic is driven with directed cases and seeded random ones. The directed cases are: a reserved code with the warm image enabled, a warm image of zero length, a warm pass, and a warm fail that falls through to flash. Further directed cases cover FPGA-direct start with a late ready and a stray validator pulse, a watchdog reset without the magic word at `last_idx`=3 (to show the wrap to slot 0), a watchdog reset with the magic word present, and all slots failing with the fallback passing and with it failing. Random cases mix every code, index, watchdog and magic combination with random pass or fail answers and a random validator latency. They are compared with the order of requests, the final status, the address and the index that a bench model predicts. This separates a wrong start slot from a wrong rotation, a wrong order of priority and a wrong end state.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [3:0] {
    ST_DECIDE,
    ST_WARM_REQ,
    ST_WARM_WAIT,
    ST_FPGA_WAIT,
    ST_SLOT_REQ,
    ST_SLOT_WAIT,
    ST_FB_REQ,
    ST_FB_WAIT,
    ST_DONE,
    ST_FALLBACK,
    ST_DEAD
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_WARM = 2'd0,
    KIND_SLOT = 2'd1,
    KIND_FPGA = 2'd2,
    KIND_NONE = 2'd3
  } val_kind_e;

  localparam logic [2:0] CODE_RESERVED = 3'd0;
  localparam logic [2:0] CODE_FPGA     = 3'd1;

endpackage

// File: rtl/boot_slot_ring.sv
module boot_slot_ring #(
  parameter int          SLOT_W = 2,
  parameter int          DATA_W = 32,
  parameter logic [31:0] MAGIC  = 32'h4953_5756
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [SLOT_W-1:0] last_idx,
  input  logic              wdog_rst,
  input  logic [DATA_W-1:0] sw_state,
  output logic [SLOT_W-1:0] start_slot,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              last_try
);
  localparam logic [SLOT_W-1:0] FINAL_TRY = '1;

  logic              magic_seen;
  logic              bump;
  logic [SLOT_W-1:0] tries_q;
  logic [SLOT_W-1:0] cur_q;

  // A watchdog reset before the preloader marked itself valid moves on one slot.
  assign magic_seen = (sw_state == DATA_W'(MAGIC));
  assign bump       = wdog_rst && !magic_seen;
  assign start_slot = last_idx + SLOT_W'(bump);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q <= '0;
      cur_q   <= '0;
    end else if (load) begin
      tries_q <= '0;
      cur_q   <= start_slot;
    end else if (advance) begin
      tries_q <= tries_q + 1'b1;
      cur_q   <= cur_q + 1'b1;
    end
  end

  assign cur_slot = cur_q;
  assign last_try = (tries_q == FINAL_TRY);

endmodule

// File: rtl/boot_req_map.sv
module boot_req_map
  import boot_seq_pkg::*;
#(
  parameter int                SLOT_W     = 2,
  parameter int                ADDR_W     = 32,
  parameter int                SLOT_SHIFT = 16,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter logic [ADDR_W-1:0] WARM_ADDR  = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FPGA_ADDR  = 32'hC000_0000
) (
  input  val_kind_e         kind,
  input  logic [SLOT_W-1:0] slot,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] slot_addr;

  assign slot_addr = FLASH_BASE + (ADDR_W'(slot) << SLOT_SHIFT);

  always_comb begin
    case (kind)
      KIND_WARM: addr = WARM_ADDR;
      KIND_SLOT: addr = slot_addr;
      KIND_FPGA: addr = FPGA_ADDR;
      default:   addr = '0;
    endcase
  end

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int                SLOT_W    = 2,
  parameter int                ADDR_W    = 32,
  parameter int                LEN_W     = 16,
  parameter logic [ADDR_W-1:0] WARM_ADDR = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FPGA_ADDR = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        boot_code,
  input  logic              warm_en,
  input  logic [LEN_W-1:0]  warm_len,
  input  logic              fpga_ready,
  input  logic              val_pass,
  input  logic              val_fail,
  input  logic              last_try,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ring_load,
  output logic              ring_advance,
  output logic              req_pulse,
  output val_kind_e         kind,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [SLOT_W-1:0] img_idx,
  output logic              done,
  output logic              fallback,
  output logic              fatal
);
  seq_state_e        state_q, state_d;
  seq_state_e        cold_next;
  logic [ADDR_W-1:0] exec_q, exec_d;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic              answered, accepted;

  assign cold_next = (boot_code == CODE_FPGA) ? ST_FPGA_WAIT : ST_SLOT_REQ;
  assign answered  = val_pass || val_fail;
  assign accepted  = val_pass;

  always_comb begin
    state_d = state_q;
    exec_d  = exec_q;
    idx_d   = idx_q;
    case (state_q)
      ST_DECIDE: begin
        idx_d = start_slot;
        if (boot_code == CODE_RESERVED) begin
          state_d = ST_DEAD;
        end else if (warm_en && (warm_len == '0)) begin
          state_d = ST_DONE;
          exec_d  = WARM_ADDR;
        end else if (warm_en) begin
          state_d = ST_WARM_REQ;
        end else begin
          state_d = cold_next;
        end
      end
      ST_WARM_REQ:  state_d = ST_WARM_WAIT;
      ST_WARM_WAIT: begin
        if (accepted) begin
          state_d = ST_DONE;
          exec_d  = req_addr;
        end else if (answered) begin
          state_d = cold_next;
        end
      end
      ST_FPGA_WAIT: begin
        if (fpga_ready) begin
          state_d = ST_DONE;
          exec_d  = FPGA_ADDR;
        end
      end
      ST_SLOT_REQ:  state_d = ST_SLOT_WAIT;
      ST_SLOT_WAIT: begin
        if (accepted) begin
          state_d = ST_DONE;
          exec_d  = req_addr;
          idx_d   = cur_slot;
        end else if (answered) begin
          state_d = last_try ? ST_FB_REQ : ST_SLOT_REQ;
        end
      end
      ST_FB_REQ:    state_d = ST_FB_WAIT;
      ST_FB_WAIT: begin
        if (accepted) begin
          state_d = ST_FALLBACK;
          exec_d  = req_addr;
        end else if (answered) begin
          state_d = ST_DEAD;
        end
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_DECIDE;
      exec_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      exec_q  <= exec_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_WARM_REQ, ST_WARM_WAIT: kind = KIND_WARM;
      ST_SLOT_REQ, ST_SLOT_WAIT: kind = KIND_SLOT;
      ST_FB_REQ, ST_FB_WAIT:     kind = KIND_FPGA;
      default:                   kind = KIND_NONE;
    endcase
  end

  assign req_pulse    = (state_q == ST_WARM_REQ) || (state_q == ST_SLOT_REQ) ||
                        (state_q == ST_FB_REQ);
  assign ring_load    = (state_q == ST_DECIDE);
  assign ring_advance = (state_q == ST_SLOT_WAIT) && val_fail && !val_pass;
  assign exec_addr    = exec_q;
  assign img_idx      = idx_q;
  assign done         = (state_q == ST_DONE);
  assign fallback     = (state_q == ST_FALLBACK);
  assign fatal        = (state_q == ST_DEAD);

endmodule

// File: rtl/boot_image_seq.sv
module boot_image_seq
  import boot_seq_pkg::*;
#(
  parameter int                SLOT_W     = 2,
  parameter int                ADDR_W     = 32,
  parameter int                LEN_W      = 16,
  parameter int                SLOT_SHIFT = 16,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter logic [ADDR_W-1:0] WARM_ADDR  = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FPGA_ADDR  = 32'hC000_0000,
  parameter logic [31:0]       MAGIC      = 32'h4953_5756
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        boot_code,
  input  logic              warm_en,
  input  logic [LEN_W-1:0]  warm_len,
  input  logic [SLOT_W-1:0] last_idx,
  input  logic [31:0]       sw_state,
  input  logic              wdog_rst,
  input  logic              fpga_ready,
  input  logic              val_pass,
  input  logic              val_fail,
  output logic              val_req,
  output logic [1:0]        val_kind,
  output logic [ADDR_W-1:0] val_addr,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [SLOT_W-1:0] img_idx,
  output logic              boot_done,
  output logic              boot_fallback,
  output logic              boot_fatal
);
  logic              ring_load, ring_advance, last_try;
  logic [SLOT_W-1:0] start_slot, cur_slot;
  val_kind_e         kind;
  logic [ADDR_W-1:0] req_addr;

  boot_slot_ring #(.SLOT_W(SLOT_W), .DATA_W(32), .MAGIC(MAGIC)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ring_load),
    .advance    (ring_advance),
    .last_idx   (last_idx),
    .wdog_rst   (wdog_rst),
    .sw_state   (sw_state),
    .start_slot (start_slot),
    .cur_slot   (cur_slot),
    .last_try   (last_try)
  );

  boot_req_map #(
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT),
    .FLASH_BASE(FLASH_BASE), .WARM_ADDR(WARM_ADDR), .FPGA_ADDR(FPGA_ADDR)
  ) u_map (
    .kind (kind),
    .slot (cur_slot),
    .addr (req_addr)
  );

  boot_seq_fsm #(
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .WARM_ADDR(WARM_ADDR), .FPGA_ADDR(FPGA_ADDR)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_code    (boot_code),
    .warm_en      (warm_en),
    .warm_len     (warm_len),
    .fpga_ready   (fpga_ready),
    .val_pass     (val_pass),
    .val_fail     (val_fail),
    .last_try     (last_try),
    .start_slot   (start_slot),
    .cur_slot     (cur_slot),
    .req_addr     (req_addr),
    .ring_load    (ring_load),
    .ring_advance (ring_advance),
    .req_pulse    (val_req),
    .kind         (kind),
    .exec_addr    (exec_addr),
    .img_idx      (img_idx),
    .done         (boot_done),
    .fallback     (boot_fallback),
    .fatal        (boot_fatal)
  );

  assign val_kind = kind;
  assign val_addr = req_addr;

endmodule

// File: rtl/boot_seq_checks.sv
module boot_seq_checks #(
  parameter int                SLOT_W     = 2,
  parameter int                ADDR_W     = 32,
  parameter int                LEN_W      = 16,
  parameter int                SLOT_SHIFT = 16,
  parameter logic [ADDR_W-1:0] WARM_ADDR  = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] FPGA_ADDR  = 32'hC000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        boot_code,
  input logic              warm_en,
  input logic [LEN_W-1:0]  warm_len,
  input logic              fpga_ready,
  input logic              val_req,
  input logic [1:0]        val_kind,
  input logic [ADDR_W-1:0] val_addr,
  input logic [ADDR_W-1:0] exec_addr,
  input logic [SLOT_W-1:0] img_idx,
  input logic              boot_done,
  input logic              boot_fallback,
  input logic              boot_fatal
);
  logic ended;
  assign ended = boot_done || boot_fallback || boot_fatal;

  assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    val_req |=> !val_req);

  assert_status_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_done, boot_fallback, boot_fatal}));

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ended |=> ($stable({boot_done, boot_fallback, boot_fatal}) &&
               $stable(exec_addr) && $stable(img_idx)));

  assert_quiet_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ended |-> !val_req);

  assert_reserved_fatal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ended && boot_code == 3'd0) |-> (boot_fatal && !val_req));

  assert_warm_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(boot_done) && warm_en && warm_len == '0 && boot_code != 3'd0)
      |-> exec_addr == WARM_ADDR);

  assert_fpga_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(boot_done) && boot_code == 3'd1 && !warm_en) |-> $past(fpga_ready));

  assert_slot_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (val_req && val_kind == 2'd1) |->
      (val_addr[SLOT_SHIFT-1:0] == '0 && (val_addr >> SLOT_SHIFT) < (1 << SLOT_W)));

  assert_fallback_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fallback |-> exec_addr == FPGA_ADDR);

endmodule

bind boot_image_seq boot_seq_checks #(
  .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SLOT_SHIFT(SLOT_SHIFT),
  .WARM_ADDR(WARM_ADDR), .FPGA_ADDR(FPGA_ADDR)
) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .boot_code     (boot_code),
  .warm_en       (warm_en),
  .warm_len      (warm_len),
  .fpga_ready    (fpga_ready),
  .val_req       (val_req),
  .val_kind      (val_kind),
  .val_addr      (val_addr),
  .exec_addr     (exec_addr),
  .img_idx       (img_idx),
  .boot_done     (boot_done),
  .boot_fallback (boot_fallback),
  .boot_fatal    (boot_fatal)
);

// File: tb/sim_boot_image_seq.sv
module sim_boot_image_seq;
  localparam logic [31:0] MAGIC_W = 32'h4953_5756;
  localparam logic [31:0] WARM_A  = 32'hFFFF_0000;
  localparam logic [31:0] FPGA_A  = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  boot_code = 3'd2;
  logic        warm_en = 1'b0;
  logic [15:0] warm_len = '0;
  logic [1:0]  last_idx = '0;
  logic [31:0] sw_state = '0;
  logic        wdog_rst = 1'b0;
  logic        fpga_ready = 1'b0;
  logic        val_pass = 1'b0;
  logic        val_fail = 1'b0;
  logic        val_req;
  logic [1:0]  val_kind;
  logic [31:0] val_addr, exec_addr;
  logic [1:0]  img_idx;
  logic        boot_done, boot_fallback, boot_fatal;

  always #5 clk = ~clk;

  boot_image_seq u0 (
    .clk(clk), .rst_n(rst_n), .boot_code(boot_code), .warm_en(warm_en),
    .warm_len(warm_len), .last_idx(last_idx), .sw_state(sw_state),
    .wdog_rst(wdog_rst), .fpga_ready(fpga_ready), .val_pass(val_pass),
    .val_fail(val_fail), .val_req(val_req), .val_kind(val_kind),
    .val_addr(val_addr), .exec_addr(exec_addr), .img_idx(img_idx),
    .boot_done(boot_done), .boot_fallback(boot_fallback), .boot_fatal(boot_fatal)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scenario
  bit          sc_warm_ok, sc_fb_ok, sc_magic;
  logic [3:0]  sc_slot_ok;
  int          sc_ready_delay;
  // expectation
  logic [1:0]  ex_kind [6];
  logic [31:0] ex_addr [6];
  int          ex_n, ex_status;
  logic [31:0] ex_exec;
  logic [1:0]  ex_idx;
  string       ex_tag;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void add_req(logic [1:0] k, logic [31:0] a);
    ex_kind[ex_n] = k;
    ex_addr[ex_n] = a;
    ex_n++;
  endfunction

  function automatic void build_expect();
    logic [1:0] start;
    bit resolved;
    ex_n = 0; ex_exec = '0; resolved = 0;
    start = last_idx + ((wdog_rst && !sc_magic) ? 2'd1 : 2'd0);
    ex_idx = start;
    if (boot_code == 3'd0) begin
      ex_status = 2; ex_tag = "R2"; resolved = 1;
    end else if (warm_en && warm_len == 16'd0) begin
      ex_status = 0; ex_exec = WARM_A; ex_tag = "R3"; resolved = 1;
    end else if (warm_en) begin
      add_req(2'd0, WARM_A);
      if (sc_warm_ok) begin
        ex_status = 0; ex_exec = WARM_A; ex_tag = "R4"; resolved = 1;
      end
    end
    if (!resolved && boot_code == 3'd1) begin
      ex_status = 0; ex_exec = FPGA_A; ex_tag = "R5"; resolved = 1;
    end
    for (int i = 0; i < 4; i++) begin
      logic [1:0] s;
      s = start + 2'(i);
      if (!resolved) begin
        add_req(2'd1, {14'd0, s, 16'd0});
        if (sc_slot_ok[s]) begin
          ex_status = 0; ex_exec = {14'd0, s, 16'd0}; ex_idx = s;
          ex_tag = "R7"; resolved = 1;
        end
      end
    end
    if (!resolved) begin
      add_req(2'd2, FPGA_A);
      if (sc_fb_ok) begin
        ex_status = 1; ex_exec = FPGA_A; ex_tag = "R8";
      end else begin
        ex_status = 2; ex_tag = "R9";
      end
    end
  endfunction

  function automatic string kind_tag(int n, logic [1:0] k);
    if (k == 2'd0) return "R4";
    if (k == 2'd2) return "R8";
    if (n == 0 || (n == 1 && ex_kind[0] == 2'd0)) return "R6";
    return "R7";
  endfunction

  task automatic run_case();
    int cyc, n_obs, pend_lat;
    bit pend, pend_ok, prev_req, stray;
    logic [2:0] st_snap;
    logic [31:0] ex_snap;
    logic [1:0] idx_snap;
    build_expect();
    stray = (boot_code == 3'd1) && !warm_en && (sc_ready_delay > 3);
    rst_n = 1'b0; fpga_ready = 1'b0; val_pass = 1'b0; val_fail = 1'b0;
    repeat (2) @(negedge clk);
    check({boot_done, boot_fallback, boot_fatal, val_req} == 4'b0 &&
          exec_addr == 0 && img_idx == 0, "R1", "reset outputs",
          {boot_done, boot_fallback, boot_fatal, val_req}, 0);
    rst_n = 1'b1;
    cyc = 0; n_obs = 0; pend = 0; pend_ok = 0; pend_lat = 0; prev_req = 0;
    while (!(boot_done || boot_fallback || boot_fatal) && cyc < 400) begin
      @(negedge clk);
      cyc++;
      val_pass = 1'b0; val_fail = 1'b0;
      if (cyc == sc_ready_delay) fpga_ready = 1'b1;
      if (pend && pend_lat == 0) begin
        val_pass = pend_ok; val_fail = !pend_ok; pend = 0;
      end else if (pend) pend_lat--;
      if (stray && cyc == 1) val_pass = 1'b1;
      if (val_req) begin
        check(!prev_req, "R10", "request longer than one cycle", 1, 0);
        if (n_obs < ex_n) begin
          check(val_kind == ex_kind[n_obs] && val_addr == ex_addr[n_obs],
                kind_tag(n_obs, ex_kind[n_obs]), "request kind/addr",
                {val_kind, val_addr}, {ex_kind[n_obs], ex_addr[n_obs]});
        end else begin
          check(0, ex_tag, "extra request", val_addr, 0);
        end
        case (val_kind)
          2'd0:    pend_ok = sc_warm_ok;
          2'd1:    pend_ok = sc_slot_ok[val_addr[17:16]];
          default: pend_ok = sc_fb_ok;
        endcase
        pend = 1; pend_lat = int'($urandom % 3);
        n_obs++;
      end
      prev_req = val_req;
      if (stray && cyc == sc_ready_delay - 1)
        check(!(boot_done || boot_fallback || boot_fatal), "R5",
              "status before fpga_ready / stray pulse (R10)",
              {boot_done, boot_fallback, boot_fatal}, 0);
    end
    val_pass = 1'b0; val_fail = 1'b0;
    check(cyc < 400, ex_tag, "sequence ended", cyc, 400);
    check(n_obs == ex_n, ex_tag, "request count", n_obs, ex_n);
    check({boot_done, boot_fallback, boot_fatal} == (3'b100 >> ex_status), ex_tag,
          "status", {boot_done, boot_fallback, boot_fatal}, 3'b100 >> ex_status);
    check(exec_addr == ex_exec, ex_tag, "exec_addr", exec_addr, ex_exec);
    check(img_idx == ex_idx, ex_tag, "img_idx", img_idx, ex_idx);
    st_snap = {boot_done, boot_fallback, boot_fatal};
    ex_snap = exec_addr; idx_snap = img_idx;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 1) begin val_pass = 1'b1; end
      else begin val_pass = 1'b0; end
      check(!val_req && {boot_done, boot_fallback, boot_fatal} == st_snap &&
            exec_addr == ex_snap && img_idx == idx_snap, "R11", "hold after end",
            {val_req, boot_done, boot_fallback, boot_fatal}, {1'b0, st_snap});
    end
    val_pass = 1'b0;
  endtask

  task automatic set_case(logic [2:0] code, bit we, logic [15:0] len, logic [1:0] last,
                          bit wd, bit mg, bit wok, logic [3:0] sok, bit fok, int rdy);
    boot_code = code; warm_en = we; warm_len = len; last_idx = last;
    wdog_rst = wd; sc_magic = mg;
    sw_state = mg ? MAGIC_W : 32'h1234_5678;
    sc_warm_ok = wok; sc_slot_ok = sok; sc_fb_ok = fok; sc_ready_delay = rdy;
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    // R2: reserved code dominates the warm image
    set_case(3'd0, 1, 16'd0, 2'd1, 0, 0, 1, 4'hF, 1, 3); run_case();
    // R3: zero-length warm image
    set_case(3'd4, 1, 16'd0, 2'd2, 0, 0, 0, 4'h0, 0, 3); run_case();
    // R4: warm pass, and warm fail into flash
    set_case(3'd5, 1, 16'd40, 2'd0, 0, 0, 1, 4'h0, 0, 3); run_case();
    set_case(3'd5, 1, 16'd40, 2'd2, 0, 0, 0, 4'b1000, 0, 3); run_case();
    // R5 and R10: FPGA direct with late ready and a stray pulse
    set_case(3'd1, 0, 16'd0, 2'd0, 0, 0, 0, 4'h0, 0, 9); run_case();
    // R6: watchdog without magic wraps 3 -> 0; with magic stays at 3
    set_case(3'd6, 0, 16'd0, 2'd3, 1, 0, 0, 4'b0001, 0, 3); run_case();
    set_case(3'd6, 0, 16'd0, 2'd3, 1, 1, 0, 4'b1001, 0, 3); run_case();
    // R8 / R9: every slot fails
    set_case(3'd7, 0, 16'd0, 2'd1, 0, 0, 0, 4'h0, 1, 3); run_case();
    set_case(3'd2, 1, 16'd8, 2'd2, 1, 0, 0, 4'h0, 0, 3); run_case();
    for (int t = 0; t < 40; t++) begin
      set_case(3'($urandom % 8), ($urandom % 3) == 0,
               ($urandom % 2) ? 16'd0 : 16'(1 + $urandom % 1000),
               2'($urandom % 4), $urandom % 2, $urandom % 2, $urandom % 2,
               {($urandom % 4) == 0, ($urandom % 4) == 0,
                ($urandom % 4) == 0, ($urandom % 4) == 0},
               $urandom % 2, 2 + int'($urandom % 8));
      run_case();
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule